// File: doc/BRIEF.md
# Parity-Coded Password Lock

This block guards entry to a clock system with a four-step recogniser. Two pushbutton levels, one for a 0 and one for a 1, are assumed to be debounced already. Each level passes through a synchroniser and a rising-edge detector, so every press becomes a single-cycle event. The password is a parameter of four BCD digits. Each digit is reduced to one expected bit by its parity, and the four bits must arrive in order, from the leftmost digit to the rightmost.

While locked, the block drives four 4-bit display codes. Each code is either a decimal digit or a reserved code for the letter E, and together they show how far entry has progressed. Any wrong bit sends the lock straight back to its start state, with no partial overlap kept. When the fourth correct bit arrives, the block enters clock mode. It lights its LEDs and raises a mode output that hands the display over to the clock logic. It stays in clock mode until reset.

Top module: `parity_lock`

## Requirements
- R1: After reset, `unlocked_o` is 0, `led_o` is 4'b0000, and all four display codes are 4'hE, so `digit_o` is 16'hEEEE.
- R2: The expected bit for a password digit is 1 when its least significant bit is 0 (even, zero included) and 0 when that bit is 1 (odd). Digits are consumed from `PASSCODE[15:12]` first to `PASSCODE[3:0]` last.
- R3: One rising edge of a button level enters exactly one bit. Holding the level high for any number of cycles enters no further bits.
- R4: If the 0 and 1 button events fall in the same clock cycle, neither is accepted and progress is unchanged.
- R5: After k correct bits (k from 0 to 3), display positions 0 to k-1 carry the first k password digits and the remaining positions carry 4'hE. Position 0 is `digit_o[15:12]`, and position 3 is `digit_o[3:0]`.
- R6: A wrong bit while locked returns progress to zero at once, with display 16'hEEEE, whatever the number of bits already accepted.
- R7: The fourth correct bit sets `unlocked_o` to 1 and `led_o` to 4'b1111, and `digit_o` then shows all four password digits.
- R8: Once unlocked, the block stays in clock mode until reset. Further button events change none of its outputs.
- R9: A bit is accepted on the third rising clock edge after its button level rises: two synchroniser edges, then the state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_zero_i | input | 1 | Debounced level of the button that enters a 0 |
| btn_one_i | input | 1 | Debounced level of the button that enters a 1 |
| digit_o | output | 16 | Four 4-bit display codes, position 0 in the top nibble; 0-9 are digits, 4'hE is the letter E |
| led_o | output | 4 | All on in clock mode, all off while locked |
| unlocked_o | output | 1 | High in clock mode |

## Verification
The state hardest to reach from the ports is a wrong bit arriving after three correct bits, because it needs the exact prefix of the password and then the opposite of the last bit. A password such as 4408 is all-even, so it never creates mixed-parity prefixes. The bench therefore runs a second instance whose password has alternating parity, and drives both with every one of the sixteen four-bit sequences, resetting before each one. This reaches every prefix length followed by every wrong bit on both instances. A reference model in the bench computes progress from digit parity by arithmetic. Held presses, same-cycle presses and presses after unlocking are added as targeted sequences.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_E = 4'hE;

  // Parity rule: even digit (LSB clear) asks for a 1.
  function automatic logic want_bit(input logic [CODE_W-1:0] dig);
    return ~dig[0];
  endfunction

  // Display rule: a position shows its digit once reached, else E.
  function automatic logic [CODE_W-1:0] show_code(input logic [CODE_W-1:0] dig,
                                                  input int unsigned pos,
                                                  input int unsigned reached);
    return (pos < reached) ? dig : CODE_E;
  endfunction
endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic [SYNC-1:0] sh;
  logic            prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[SYNC-2:0], lvl_i};
      prev <= sh[SYNC-1];
    end
  end

  assign rise_o = sh[SYNC-1] & ~prev;
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  parameter logic [CODE_W*DIGITS-1:0] PASSCODE = 16'h4408,
  localparam int unsigned CNT_W = $clog2(DIGITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_zero_i,
  input  logic             ev_one_i,
  output logic [CNT_W-1:0] progress_o,
  output logic             open_o
);
  logic [CNT_W-1:0] progress_q, progress_d;
  logic             take, exp_bit;

  assign take = ev_zero_i ^ ev_one_i;

  always_comb begin
    exp_bit = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (progress_q == CNT_W'(i))
        exp_bit = want_bit(PASSCODE[(DIGITS-1-i)*CODE_W +: CODE_W]);
    end
  end

  always_comb begin
    progress_d = progress_q;
    if (!open_o && take) begin
      if (ev_one_i == exp_bit) progress_d = progress_q + 1'b1;
      else                     progress_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) progress_q <= '0;
    else        progress_q <= progress_d;
  end

  assign progress_o = progress_q;
  assign open_o     = (progress_q == CNT_W'(DIGITS));
endmodule

// File: rtl/lock_disp.sv
module lock_disp
  import lock_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  parameter logic [CODE_W*DIGITS-1:0] PASSCODE = 16'h4408,
  localparam int unsigned CNT_W = $clog2(DIGITS + 1)
) (
  input  logic [CNT_W-1:0]         progress_i,
  output logic [CODE_W*DIGITS-1:0] digit_o
);
  for (genvar p = 0; p < DIGITS; p++) begin : g_pos
    localparam int unsigned LSB = (DIGITS - 1 - p) * CODE_W;
    assign digit_o[LSB +: CODE_W] =
      show_code(PASSCODE[LSB +: CODE_W], p, int'(progress_i));
  end
endmodule

// File: rtl/parity_lock.sv
module parity_lock
  import lock_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  parameter logic [CODE_W*DIGITS-1:0] PASSCODE = 16'h4408,
  parameter int unsigned SYNC = 2,
  parameter int unsigned LED_N = 4,
  localparam int unsigned CNT_W = $clog2(DIGITS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     btn_zero_i,
  input  logic                     btn_one_i,
  output logic [CODE_W*DIGITS-1:0] digit_o,
  output logic [LED_N-1:0]         led_o,
  output logic                     unlocked_o
);
  logic             ev_zero, ev_one, open_mode;
  logic [CNT_W-1:0] progress;

  btn_edge #(.SYNC(SYNC)) u_zero (.clk(clk), .rst_n(rst_n), .lvl_i(btn_zero_i), .rise_o(ev_zero));
  btn_edge #(.SYNC(SYNC)) u_one  (.clk(clk), .rst_n(rst_n), .lvl_i(btn_one_i),  .rise_o(ev_one));

  lock_seq #(.DIGITS(DIGITS), .PASSCODE(PASSCODE)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_zero_i(ev_zero), .ev_one_i(ev_one),
    .progress_o(progress), .open_o(open_mode)
  );

  lock_disp #(.DIGITS(DIGITS), .PASSCODE(PASSCODE)) u_disp (
    .progress_i(progress), .digit_o(digit_o)
  );

  assign led_o      = {LED_N{open_mode}};
  assign unlocked_o = open_mode;
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
  parameter int unsigned DIGITS = 4,
  parameter int unsigned LED_N = 4,
  localparam int unsigned CNT_W = $clog2(DIGITS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_zero,
  input logic               ev_one,
  input logic [CNT_W-1:0]   progress,
  input logic [4*DIGITS-1:0] digit_o,
  input logic [LED_N-1:0]   led_o,
  input logic               unlocked_o
);
  // R6
  step_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (progress != $past(progress)) |-> ((progress == $past(progress) + 1'b1) || (progress == '0)));

  // R8
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_o |=> (unlocked_o && $stable(digit_o)));

  // R4
  dual_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_zero && ev_one) |=> $stable(progress));

  // R3
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_one |=> !ev_one);

  // R3
  zero_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> !ev_zero);

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_zero && !ev_one) |=> $stable(progress));

  // R5
  locked_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_o |-> (digit_o[3:0] == 4'hE));

  // R7
  led_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_o ? (led_o == {LED_N{1'b1}}) : (led_o == '0));
endmodule

bind parity_lock lock_chk #(.DIGITS(DIGITS), .LED_N(LED_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_zero(ev_zero), .ev_one(ev_one),
  .progress(progress), .digit_o(digit_o), .led_o(led_o), .unlocked_o(unlocked_o)
);

// File: tb/sim_parity_lock.sv
module sim_parity_lock;
  localparam logic [15:0] PASS_A = 16'h4408;
  localparam logic [15:0] PASS_B = 16'h5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b0 = 1'b0, b1 = 1'b0;
  logic [15:0] dig_a, dig_b;
  logic [3:0]  led_a, led_b;
  logic        open_a, open_b;
  int n_cmp = 0, n_bad = 0;
  int ka, kb;
  bit done = 0;

  always #10 clk = ~clk;

  parity_lock u0 (.clk(clk), .rst_n(rst_n), .btn_zero_i(b0), .btn_one_i(b1),
                  .digit_o(dig_a), .led_o(led_a), .unlocked_o(open_a));
  parity_lock #(.PASSCODE(PASS_B)) u1 (.clk(clk), .rst_n(rst_n), .btn_zero_i(b0), .btn_one_i(b1),
                  .digit_o(dig_b), .led_o(led_b), .unlocked_o(open_b));

  function automatic int dig_of(logic [15:0] pw, int p);
    return int'((pw >> (4 * (3 - p))) & 16'hF);
  endfunction

  function automatic bit exp_of(logic [15:0] pw, int k);
    return (dig_of(pw, k) % 2) == 0;
  endfunction

  function automatic logic [15:0] disp_of(logic [15:0] pw, int k);
    logic [15:0] r = 16'd0;
    for (int p = 0; p < 4; p++)
      r = r | (16'((p < k) ? dig_of(pw, p) : 14) << (4 * (3 - p)));
    return r;
  endfunction

  function automatic int step(logic [15:0] pw, int k, bit b);
    if (k >= 4) return k;
    return (b == exp_of(pw, k)) ? k + 1 : 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic check_both(string tag);
    check({tag, " u0 digits"}, 32'(dig_a), 32'(disp_of(PASS_A, ka)));
    check({tag, " u1 digits"}, 32'(dig_b), 32'(disp_of(PASS_B, kb)));
    check({tag, " u0 led"}, 32'(led_a), (ka == 4) ? 32'hF : 32'h0);
    check({tag, " u1 led"}, 32'(led_b), (kb == 4) ? 32'hF : 32'h0);
    check({tag, " u0 mode"}, 32'(open_a), 32'(ka == 4));
    check({tag, " u1 mode"}, 32'(open_b), 32'(kb == 4));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; b0 = 1'b0; b1 = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ka = 0; kb = 0;
  endtask

  task automatic press(bit b);
    @(negedge clk);
    if (b) b1 = 1'b1; else b0 = 1'b1;
    repeat (4) @(negedge clk);
    b0 = 1'b0; b1 = 1'b0;
    repeat (4) @(negedge clk);
    ka = step(PASS_A, ka, b);
    kb = step(PASS_B, kb, b);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 u0 digits", 32'(dig_a), 32'hEEEE);
    check("R1 u0 led", 32'(led_a), 32'h0);
    check("R1 u0 mode", 32'(open_a), 32'h0);

    // R2 R5 R6 R7: every four-bit sequence on both passwords
    for (int s = 0; s < 16; s++) begin
      do_reset();
      for (int j = 0; j < 4; j++) begin
        press(s[3 - j]);
        check_both("R2/R5/R6/R7 sweep");
      end
    end

    // R9 latency: accepted on third edge after the level rises
    do_reset();
    @(negedge clk); b1 = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 before third edge", 32'(dig_a), 32'hEEEE);
    @(negedge clk);
    check("R9 after third edge", 32'(dig_a), 32'h4EEE);
    b1 = 1'b0; repeat (4) @(negedge clk);

    // R3 holding a button enters one bit only
    do_reset();
    @(negedge clk); b1 = 1'b1;
    repeat (30) @(negedge clk);
    check("R3 held press", 32'(dig_a), 32'h4EEE);
    b1 = 1'b0; repeat (4) @(negedge clk);

    // R4 simultaneous edges are dropped
    do_reset();
    press(1'b0); // u1: 5 odd, accepted
    @(negedge clk); b0 = 1'b1; b1 = 1'b1;
    repeat (6) @(negedge clk); b0 = 1'b0; b1 = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 dual press u0", 32'(dig_a), 32'hEEEE);
    check("R4 dual press u1", 32'(dig_b), 32'h5EEE);

    // R6 wrong bit after three correct
    do_reset();
    press(1'b0); press(1'b1); press(1'b0);
    check("R6 three correct", 32'(dig_b), 32'h567E);
    press(1'b0);
    check("R6 wrong fourth", 32'(dig_b), 32'hEEEE);

    // R7 R8 unlock then ignore further presses
    do_reset();
    press(1'b0); press(1'b1); press(1'b0); press(1'b1);
    check("R7 unlock digits", 32'(dig_b), 32'h5678);
    check("R7 unlock led", 32'(led_b), 32'hF);
    press(1'b0); press(1'b1); press(1'b1);
    check("R8 held digits", 32'(dig_b), 32'h5678);
    check("R8 held mode", 32'(open_b), 32'h1);
    check("R8 held led", 32'(led_b), 32'hF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule